// File: doc/BRIEF.md
# Dual-Register I2C Slave with Address-Bit Register Select

This block is a bus slave for a two-wire serial bus. It holds two 8-bit registers and exposes both of them as parallel outputs. Which register a transfer touches is set by one bit of the 7-bit device address. There is no pointer or sub-address byte, so the device answers to two bus addresses. One more address bit comes from a strap input. Two copies of the block can therefore sit on the same bus.

A fast system clock oversamples SCL and SDA through synchronizers. The block finds START and STOP conditions, shifts in the address byte, and acknowledges when the address matches. It then either stores each received data byte in the selected register or returns that register's value to the master. It drives SDA only through an open-drain pull-down output. It supports both 100 kHz and 400 kHz bus rates, provided the system clock is many times faster than SCL.

Top module: `i2c_dualreg_slave`

## Requirements
- R1: After reset both registers read 00h and the SDA pull-down output is inactive.
- R2: The first byte after START is accepted only when bits 7..3 equal 01000 and bit 2 equals the strap level (high = 1). Any other byte gets no acknowledge, and the data bytes that follow are ignored.
- R3: Address bit 1 picks the register (0 = register 0, 1 = register 1) and bit 0 the direction (1 = read, 0 = write). The write addresses are therefore 40h/42h with the strap low and 44h/46h with the strap high.
- R4: When addressed, the slave holds SDA low over the whole high phase of the ninth SCL pulse after each byte it receives. This holds at both 100 kHz and 400 kHz.
- R5: In a write, every data byte overwrites the selected register. The other register is unchanged.
- R6: In a read, the selected register is sent MSB first. The same value is sent again for each byte the master acknowledges.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next START.
- R8: A repeated START without a STOP restarts address reception, so a new address and direction take effect.
- R9: A STOP in the middle of a byte aborts the transfer and leaves both registers unchanged.
- R10: The SDA pull-down output changes only while SCL is low. Incoming data bits are sampled on SCL rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 1 | Address strap; sets address bit 2 |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg0_o | output | 8 | Contents of register 0 |
| reg1_o | output | 8 | Contents of register 1 |

## Verification
Each bus line passes through two synchronizer flops and one edge-history flop. The FSM then registers its result. So the pull-down output and a register write appear on the third clock edge after the SCL edge that causes them. That is well inside every SCL phase. The bench samples the acknowledge and read data in the middle of each SCL high phase, far from that settling point. The reference register values are compared on every system clock. Comparison is paused for eight clocks after the eighth falling edge of each byte, which is the only point where a write lands.

// File: rtl/i2c_dr_pkg.sv
`timescale 1ns/1ps
package i2c_dr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } bus_state_t;
  localparam logic [4:0] DEV_PATTERN = 5'b01000;
endpackage

// File: rtl/i2c_dr_linesync.sv
`timescale 1ns/1ps
module i2c_dr_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
      scl_p <= scl_ff[STAGES-1];
      sda_p <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_dr_regbank.sv
`timescale 1ns/1ps
module i2c_dr_regbank #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 2,
  localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [DATA_W-1:0]                rd_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (sel == SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[g] <= '0;
      else if (hit) regs_q[g] <= wr_data;
    end
  end

  assign rd_data = regs_q[sel];
  assign regs_o  = regs_q;

  // R5
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
endmodule

// File: rtl/i2c_dr_engine.sv
`timescale 1ns/1ps
module i2c_dr_engine
  import i2c_dr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              strap_i,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sel_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sda_pull_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  bus_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              sel_q, sel_d, rw_q, rw_d, nack_q, nack_d, pull_q, pull_d;
  logic              addr_ok;

  assign addr_ok = (shift_q[DATA_W-1:DATA_W-5] == DEV_PATTERN) && (shift_q[2] == strap_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    sel_d   = sel_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    pull_d  = pull_q;
    wr_en_o = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shift_d = {shift_q[DATA_W-2:0], sda_s};
            cnt_d   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == LAST) begin
            cnt_d = '0;
            if (state_q == ST_WDATA) begin
              wr_en_o = 1'b1;
              pull_d  = 1'b1;
              state_d = ST_WACK;
            end else if (addr_ok) begin
              sel_d   = shift_q[1];
              rw_d    = shift_q[0];
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              shift_d = rd_data;
              pull_d  = ~rd_data[DATA_W-1];
              state_d = ST_RDATA;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WDATA;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == LAST) begin
              pull_d  = 1'b0;
              cnt_d   = '0;
              state_d = ST_RACK;
            end else begin
              shift_d = {shift_q[DATA_W-2:0], 1'b0};
              pull_d  = ~shift_q[DATA_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            if (nack_q) begin
              pull_d  = 1'b0;
              state_d = ST_IDLE;
            end else begin
              shift_d = rd_data;
              pull_d  = ~rd_data[DATA_W-1];
              state_d = ST_RDATA;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      sel_q   <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      sel_q   <= sel_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      pull_q  <= pull_d;
    end
  end

  assign sel_o      = sel_q;
  assign wr_data_o  = shift_q;
  assign sda_pull_o = pull_q;

  // R10
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> (!scl_s || $past(start_det || stop_det)));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state_q == ST_IDLE) && !pull_q);
  // R8
  start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR) && (cnt_q == '0));
  // R2
  strap_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR) && scl_fall && (cnt_q == LAST) && (shift_q[2] != strap_i)
      && !start_det && !stop_det |=> (state_q == ST_IDLE) && !pull_q);
  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !pull_q);
endmodule

// File: rtl/i2c_dualreg_slave.sv
`timescale 1ns/1ps
module i2c_dualreg_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_pull_o,
  output logic [DATA_W-1:0] reg0_o,
  output logic [DATA_W-1:0] reg1_o
);
  localparam int NUM_REGS = 2;

  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic sel, wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  i2c_dr_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c_dr_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n_int), .scl_s(scl_s), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .strap_i(strap_i), .rd_data(rd_data),
    .sel_o(sel), .wr_en_o(wr_en), .wr_data_o(wr_data), .sda_pull_o(sda_pull_o)
  );

  i2c_dr_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .sel(sel),
    .wr_data(wr_data), .rd_data(rd_data), .regs_o(regs)
  );

  assign reg0_o = regs[0];
  assign reg1_o = regs[1];
endmodule

// File: tb/i2c_dualreg_slave_test.sv
`timescale 1ns/1ps
module i2c_dualreg_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic sda_pull;
  logic [7:0] reg0, reg1;
  wire sda_line = sda_m & ~sda_pull;

  int errors = 0, checks = 0, grace = 0, q = 1248;
  bit mon_on = 1'b0;
  logic prev_pull = 1'b0;
  logic [7:0] exp_reg [2];

  always #2 clk = ~clk;

  i2c_dualreg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .strap_i(strap),
    .sda_pull_o(sda_pull), .reg0_o(reg0), .reg1_o(reg1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference register model compared on every clock, paused after each byte
  always @(negedge clk) begin
    if (mon_on) begin
      if (grace > 0) grace--;
      else begin
        chk(reg0 == exp_reg[0], "R5 reg0", reg0, exp_reg[0]);
        chk(reg1 == exp_reg[1], "R5 reg1", reg1, exp_reg[1]);
      end
      if (sda_pull != prev_pull) chk(scl_m == 1'b0, "R10 pull change with SCL", scl_m, 0);
      prev_pull = sda_pull;
    end
  end

  task automatic bus_start();
    #(q/2) sda_m = 1'b1;
    #(q/2) scl_m = 1'b1;
    #(q/2) sda_m = 1'b0;
    #(q/2) scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    #(q/2) sda_m = 1'b0;
    #(q/2) scl_m = 1'b1;
    #(q/2) sda_m = 1'b1;
    #q;
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      #(q/2) sda_m = b[7-i];
      #(q/2) scl_m = 1'b1;
      #q     scl_m = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input int wr_idx, output bit acked);
    logic s1, s2;
    put_bits(b, 8);
    grace = 8;
    if (wr_idx >= 0) exp_reg[wr_idx] = b;
    #(q/2) sda_m = 1'b1;
    #(q/2) scl_m = 1'b1;
    #(q/2) s1 = sda_line;
    #(q/2) s2 = sda_line;
    scl_m = 1'b0;
    acked = (s1 == 1'b0) && (s2 == 1'b0);
  endtask

  task automatic get_byte(input bit ack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      #(q/2) sda_m = 1'b1;
      #(q/2) scl_m = 1'b1;
      #(q/2) d[7-i] = sda_line;
      #(q/2) scl_m = 1'b0;
    end
    #(q/2) sda_m = ~ack;
    #(q/2) scl_m = 1'b1;
    #q     scl_m = 1'b0;
    #(q/2) sda_m = 1'b1;
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    exp_reg[0] = 8'h00;
    exp_reg[1] = 8'h00;
    #41;
    // R1: reset state
    chk(reg0 == 8'h00 && reg1 == 8'h00, "R1 regs in reset", {reg1, reg0}, 0);
    chk(sda_pull == 1'b0, "R1 pull in reset", sda_pull, 0);
    rst_n = 1'b1;
    #40;
    chk(reg0 == 8'h00 && reg1 == 8'h00, "R1 regs after reset", {reg1, reg0}, 0);
    mon_on = 1'b1;

    // R3 R4 R5: write register 0 at 40h
    bus_start();
    put_byte(8'h40, -1, a); chk(a, "R4 ack addr 40h", a, 1);
    put_byte(8'hA5, 0, a);  chk(a, "R4 ack data", a, 1);
    bus_stop();

    // R5: two bytes to register 1 at 42h, last one wins
    bus_start();
    put_byte(8'h42, -1, a); chk(a, "R3 ack addr 42h", a, 1);
    put_byte(8'h3C, 1, a);  chk(a, "R5 ack byte1", a, 1);
    put_byte(8'h7E, 1, a);  chk(a, "R5 ack byte2", a, 1);
    bus_stop();

    // R2: strap mismatch at 44h with strap low, data ignored
    bus_start();
    put_byte(8'h44, -1, a); chk(!a, "R2 no ack 44h strap low", a, 0);
    put_byte(8'hFF, -1, a); chk(!a, "R2 no ack data", a, 0);
    bus_stop();

    // R6 R7: read register 0 twice then NACK
    bus_start();
    put_byte(8'h41, -1, a); chk(a, "R3 ack read 41h", a, 1);
    get_byte(1'b1, d);      chk(d == 8'hA5, "R6 read byte1", d, 8'hA5);
    get_byte(1'b0, d);      chk(d == 8'hA5, "R6 read byte2", d, 8'hA5);
    chk(sda_pull == 1'b0, "R7 released after nack", sda_pull, 0);
    get_byte(1'b0, d);      chk(d == 8'hFF, "R7 no data after nack", d, 8'hFF);
    bus_stop();

    // R2 R3: strap high moves addresses
    strap = 1'b1;
    bus_start();
    put_byte(8'h42, -1, a); chk(!a, "R2 no ack 42h strap high", a, 0);
    bus_stop();
    bus_start();
    put_byte(8'h46, -1, a); chk(a, "R3 ack 46h", a, 1);
    put_byte(8'h11, 1, a);  chk(a, "R5 ack data 46h", a, 1);
    bus_stop();

    // R8: write then repeated START into a read of the other register
    bus_start();
    put_byte(8'h44, -1, a); chk(a, "R8 ack 44h", a, 1);
    put_byte(8'h99, 0, a);  chk(a, "R8 ack data", a, 1);
    bus_start();
    put_byte(8'h47, -1, a); chk(a, "R8 ack after repeated start", a, 1);
    get_byte(1'b0, d);      chk(d == 8'h11, "R8 read reg1", d, 8'h11);
    bus_stop();

    // R9: STOP halfway through a data byte
    bus_start();
    put_byte(8'h44, -1, a); chk(a, "R9 ack 44h", a, 1);
    put_bits(8'hF0, 4);
    bus_stop();
    #400;
    chk(reg0 == 8'h99, "R9 reg0 kept after abort", reg0, 8'h99);

    // R4: 100 kHz rate
    q = 5000;
    bus_start();
    put_byte(8'h46, -1, a); chk(a, "R4 ack 100k addr", a, 1);
    put_byte(8'h5A, 1, a);  chk(a, "R4 ack 100k data", a, 1);
    bus_stop();
    #400;
    chk(reg1 == 8'h5A, "R5 reg1 at 100k", reg1, 8'h5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule